// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses the direction of conditional branches for a simple in-order pipeline. It holds a table of 2-bit saturating counters, one per table slot. The slot is chosen by a few low-order bits of the branch's program counter. The fetch stage raises a lookup request together with the fetch PC. One cycle later the block returns a taken or not-taken guess, the counter value it was read from, and a valid flag.

Branch outcomes are known only later, in the execute or memory stage. The block therefore has a second, independent port for training. That stage presents the resolving branch's PC, the actual direction and a write enable. The counter in the matching slot then moves one step toward that direction. Lookups and training can happen in the same cycle, including on the same slot.

Top module: `bimodal_predictor`

## Requirements
- R1: A synchronous active-high reset sets every counter to weakly-not-taken (value 1) and drives `lookup_valid` low.
- R2: `lookup_valid` is high in exactly the cycle after a cycle in which `lookup_req` was high, and is low otherwise.
- R3: The counter encoding is 0 strongly-not-taken, 1 weakly-not-taken, 2 weakly-taken, 3 strongly-taken. `lookup_ctr` returns the value read, and `lookup_taken` equals its bit 1.
- R4: A training event with `resolve_taken` high raises the slot's counter by one, and a counter at 3 stays at 3.
- R5: A training event with `resolve_taken` low lowers the slot's counter by one, and a counter at 0 stays at 0.
- R6: The slot index is PC bits [IDX_W+ALIGN_W-1:ALIGN_W]. PC bits below and above that field have no effect on which counter is used.
- R7: While `resolve_en` is low, no counter changes, whatever the other training inputs are.
- R8: When a lookup and a training event hit the same slot in the same cycle, the lookup returns the value from before the update. The next lookup of that slot sees the updated value.
- R9: A training event changes only the counter of its own slot.
- R10: In a cycle after one with no request, `lookup_taken` and `lookup_ctr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_req | input | 1 | Fetch-side prediction request |
| lookup_pc | input | PC_W | PC of the instruction being fetched |
| lookup_valid | output | 1 | Response valid, one cycle after the request |
| lookup_taken | output | 1 | Predicted direction (1 = taken) |
| lookup_ctr | output | 2 | Counter value the prediction came from |
| resolve_en | input | 1 | Training write enable from the resolve stage |
| resolve_pc | input | PC_W | PC of the resolving branch |
| resolve_taken | input | 1 | Actual branch direction |

## Verification
The bench builds the block with its defaults: a 32-bit PC, 2 alignment bits and a 6-bit index, which gives 64 slots. With only 64 slots, random PCs confined to a small address window hit the same slot often. Same-cycle collisions of lookup and training, and counters pinned at both saturation limits, therefore occur many times in the random phase. Directed sequences add aliasing PCs that differ only above or below the index field.

// File: rtl/bimodal_pkg.sv
package bimodal_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_e;

    localparam ctr_e CTR_INIT = CTR_WNT;

    // one saturating step toward the observed direction
    function automatic ctr_e ctr_step(input ctr_e cur, input logic went_taken);
        ctr_e nxt;
        nxt = cur;
        if (went_taken) begin
            if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_pc_index.sv
module bp_pc_index #(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2,
    parameter int IDX_W   = 6
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    localparam int TOP = IDX_W + ALIGN_W - 1;

    assign idx = pc[TOP:ALIGN_W];

    initial begin
        idx_fits_chk: assert (TOP < PC_W);
    end
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bimodal_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_e             rd_state
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_e cells [DEPTH];
    ctr_e wr_old;

    assign wr_old   = cells[wr_idx];
    assign rd_state = cells[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= CTR_INIT;
        end else if (wr_en) begin
            cells[wr_idx] <= ctr_step(wr_old, wr_taken);
        end
    end

    // R4
    up_never_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_taken |=> cells[$past(wr_idx)] != CTR_SNT);
    // R5
    down_never_top_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_taken |=> cells[$past(wr_idx)] != CTR_ST);
    // R7
    idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> cells[$past(rd_idx)] == $past(rd_state));
endmodule

// File: rtl/bp_lookup.sv
module bp_lookup
    import bimodal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  ctr_e rd_state,
    output logic valid,
    output logic taken,
    output ctr_e state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            taken <= 1'b0;
            state <= CTR_INIT;
        end else begin
            valid <= req;
            if (req) begin
                state <= rd_state;
                taken <= ctr_says_taken(rd_state);
            end
        end
    end

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> valid);
    // R2
    valid_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> !valid);
    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable(state) && $stable(taken));
    // R3
    taken_is_msb_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> taken == $past(rd_state[1]));
endmodule

// File: rtl/bimodal_predictor.sv
module bimodal_predictor
    import bimodal_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2,
    parameter int IDX_W   = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lookup_req,
    input  logic [PC_W-1:0] lookup_pc,
    output logic            lookup_valid,
    output logic            lookup_taken,
    output logic [1:0]      lookup_ctr,
    input  logic            resolve_en,
    input  logic [PC_W-1:0] resolve_pc,
    input  logic            resolve_taken
);
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    ctr_e             rd_state;
    ctr_e             out_state;

    bp_pc_index #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_rd_index (
        .pc  (lookup_pc),
        .idx (rd_idx)
    );

    bp_pc_index #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_wr_index (
        .pc  (resolve_pc),
        .idx (wr_idx)
    );

    bp_ctr_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (resolve_en),
        .wr_idx   (wr_idx),
        .wr_taken (resolve_taken),
        .rd_idx   (rd_idx),
        .rd_state (rd_state)
    );

    bp_lookup u_lookup (
        .clk      (clk),
        .rst      (rst),
        .req      (lookup_req),
        .rd_state (rd_state),
        .valid    (lookup_valid),
        .taken    (lookup_taken),
        .state    (out_state)
    );

    assign lookup_ctr = out_state;

    // R8
    read_before_write_chk: assert property (@(posedge clk) disable iff (rst)
        lookup_req && resolve_en && rd_idx == wr_idx |=> lookup_ctr == $past(rd_state));
    // R1
    reset_clears_valid_chk: assert property (@(posedge clk)
        rst |=> !lookup_valid);
endmodule

// File: tb/bimodal_predictor_test.sv
`timescale 1ns/1ps
module bimodal_predictor_test;
    localparam int PC_W = 32;
    localparam int ALIGN_W = 2;
    localparam int IDX_W = 6;
    localparam int DEPTH = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst;
    logic lookup_req;
    logic [PC_W-1:0] lookup_pc;
    logic lookup_valid;
    logic lookup_taken;
    logic [1:0] lookup_ctr;
    logic resolve_en;
    logic [PC_W-1:0] resolve_pc;
    logic resolve_taken;

    int checks = 0;
    int failures = 0;
    int model [DEPTH];
    int last_ctr = 1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bimodal_predictor #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst(rst),
        .lookup_req(lookup_req), .lookup_pc(lookup_pc),
        .lookup_valid(lookup_valid), .lookup_taken(lookup_taken), .lookup_ctr(lookup_ctr),
        .resolve_en(resolve_en), .resolve_pc(resolve_pc), .resolve_taken(resolve_taken)
    );

    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return int'((pc >> ALIGN_W) & (DEPTH - 1));
    endfunction

    function automatic int step(input int c, input bit t);
        if (t) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, compute expectation, check at next negedge
    task automatic cycle(input bit rq, input logic [PC_W-1:0] rpc,
                         input bit we, input logic [PC_W-1:0] wpc, input bit wt,
                         input string tag);
        int exp_ctr;
        lookup_req = rq; lookup_pc = rpc;
        resolve_en = we; resolve_pc = wpc; resolve_taken = wt;
        exp_ctr = rq ? model[idx_of(rpc)] : last_ctr;
        if (we) model[idx_of(wpc)] = step(model[idx_of(wpc)], wt);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R2 valid"}, int'(lookup_valid), int'(rq));
        check({tag, " ctr"}, int'(lookup_ctr), exp_ctr);
        check({tag, " R3 taken"}, int'(lookup_taken), (exp_ctr >= 2) ? 1 : 0);
        last_ctr = exp_ctr;
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input string tag);
        cycle(1'b1, pc, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic train(input logic [PC_W-1:0] pc, input bit t, input string tag);
        cycle(1'b0, '0, 1'b1, pc, t, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) model[i] = 1;
        rst = 1'b1; lookup_req = 0; lookup_pc = '0;
        resolve_en = 0; resolve_pc = '0; resolve_taken = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid low in reset", int'(lookup_valid), 0);
        rst = 1'b0;

        // R1: every slot starts weakly-not-taken
        look(32'h0, "R1 slot0");
        look(32'h14, "R1 slot5");
        look(32'hFC, "R1 slot63");

        // R4 / R5 saturation on slot 3
        for (int k = 0; k < 4; k++) train(32'hC, 1'b1, "R4 up");
        look(32'hC, "R4 saturated high");
        for (int k = 0; k < 5; k++) train(32'hC, 1'b0, "R5 down");
        look(32'hC, "R5 saturated low");

        // R9: neighbours untouched
        look(32'h8, "R9 slot2");
        look(32'h10, "R9 slot4");

        // R8: same-cycle collision on slot 7
        cycle(1'b1, 32'h1C, 1'b1, 32'h1C, 1'b1, "R8 old value");
        look(32'h1C, "R8 new value");

        // R6: aliasing above and below index field
        train(32'h0000_0120, 1'b1, "R6 train");
        look(32'h0000_0023, "R6 alias low bits");
        look(32'h8000_0020, "R6 alias high bits");

        // R7: enable low, taken high -> no change on slot 9
        cycle(1'b0, '0, 1'b0, 32'h24, 1'b1, "R7 idle");
        cycle(1'b0, '0, 1'b0, 32'h24, 1'b1, "R7 idle");
        look(32'h24, "R7 unchanged");

        // R10: hold after idle cycle
        cycle(1'b0, 32'hC, 1'b0, '0, 1'b0, "R10 hold");

        // random phase in a narrow window to force collisions
        for (int n = 0; n < 4000; n++) begin
            logic [PC_W-1:0] a, b;
            a = PC_W'($urandom_range(0, 63)) << 2 | PC_W'($urandom_range(0, 3));
            b = (($urandom_range(0, 3) == 0) ? a : (PC_W'($urandom_range(0, 63)) << 2))
                | (PC_W'($urandom_range(0, 1)) << 20);
            cycle($urandom_range(0, 3) != 0, a,
                  $urandom_range(0, 2) != 0, b,
                  $urandom_range(0, 1) == 1, "R4 R5 R6 R8 R9 random");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule